// File: doc/BRIEF.md
# Multichannel Endpoint DMA Engine

This block moves bytes between endpoint FIFOs and system memory on eight independent channels. Software programs a channel through a small register window: a start address, a byte count, and then a control word whose enable bit launches the channel. Each endpoint then paces the channel with request pulses. On every pulse the channel moves one packet, splitting it into memory bursts whose size comes from the control word. The bursts are placed on a shared memory port, one beat per byte.

Progress appears as a live address pointer. The bytes moved so far equal the current address minus the programmed start. A count register alongside it counts the bytes still to move. A channel ends either by finishing its transfer or by taking a memory bus error. Either event can post a per-channel interrupt flag, which clears when software reads it. Channels that compete for the memory port are served in turn, one burst per grant.

Top module: `ep_dma_engine`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and no memory beat is issued.
- R2: The interrupt status register sits at offset 0x200, with bit n for channel n. Channel n occupies 0x200+16n and has control at +4, address at +8 and count at +0xC. Control bit 0 is enable, bit 1 is direction (1 = memory to endpoint), bit 2 is mode 1 (multi-packet), bit 3 is interrupt enable, bits 7:4 hold the endpoint number, bit 8 is the bus-error flag and bits 10:9 select the burst. A control word written with enable clear reads back unchanged.
- R3: Writing control with enable set arms the channel. No memory beat is issued for a channel until its endpoint request pulse arrives.
- R4: Each accepted beat presents the channel's current address and then advances it by one, so the bytes moved equal the address minus the start. Each good beat lowers the count by one. `mem_write_o` is the inverse of the direction bit.
- R5: The count register holds values up to 0x10000. No beat is ever issued beyond the remaining count.
- R6: The burst length is 1, 4, 8 or 16 beats for burst codes 0, 1, 2 and 3, cut short to the bytes left in the current packet.
- R7: In mode 0, one request moves min(64, count) bytes. Enable then clears, even when some count remains.
- R8: In mode 1, each request moves the next packet of up to 64 bytes. Enable stays set until the count reaches zero.
- R9: When several channels want the memory port, grants rotate round-robin, one whole burst per grant.
- R10: A beat answered with `mem_err_i` does not advance the address. It sets control bit 8, clears enable and stops the channel.
- R11: A completion or an error sets the channel's status bit only when its interrupt enable is 1. Reading the status register clears it, and `irq_o` is the OR of the status bits.
- R12: Writing zero to control, address and count stops an active channel. No further beats are issued and all three read back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears status on read) |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| ep_req_i | input | 8 | Per-channel endpoint packet request pulse |
| irq_o | output | 1 | Interrupt, OR of status bits |
| mem_valid_o | output | 1 | Memory beat valid |
| mem_ready_i | input | 1 | Memory beat accepted |
| mem_err_i | input | 1 | Memory bus error on the accepted beat |
| mem_write_o | output | 1 | 1 = write to memory |
| mem_addr_o | output | 32 | Beat byte address |
| mem_len_o | output | 5 | Beats in the current burst |
| mem_last_o | output | 1 | Final beat of the burst |
| mem_chan_o | output | 3 | Channel owning the burst |

## Verification
A register write takes effect at the next clock edge. An endpoint pulse opens a packet at its edge. The arbiter grants at the following edge, and the first beat is valid one cycle after the grant. The address, count and status all update at the same edge that accepts a beat, so a status bit and `irq_o` are visible one cycle after the last beat or the error beat. The bench drives inputs on the falling edge and samples a quarter period before the rising edge. Its model applies each beat and each status read in that sampling slot, so every comparison is made against the state due at that edge.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  localparam int LEN_W = 5;

  typedef struct packed {
    logic [1:0] burst;
    logic       berr;
    logic [3:0] ep;
    logic       ie;
    logic       mode;
    logic       dir;
    logic       en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [LEN_W-1:0] burst_beats(input logic [1:0] sel);
    case (sel)
      2'd1:    return LEN_W'(4);
      2'd2:    return LEN_W'(8);
      2'd3:    return LEN_W'(16);
      default: return LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ep_dma_chan.sv
module ep_dma_chan
  import ep_dma_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int CNT_W     = 17,
  parameter int PKT_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             addr_we_i,
  input  logic             cnt_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ep_req_i,
  input  logic             beat_i,
  input  logic             err_i,
  output ctl_t             ctl_o,
  output logic [AW-1:0]    addr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             need_o,
  output logic [LEN_W-1:0] blen_o,
  output logic             done_o
);
  ctl_t             ctl_q;
  logic [AW-1:0]    addr_q;
  logic [CNT_W-1:0] cnt_q, pkt_q;
  logic             act_q;
  logic [LEN_W-1:0] bb;
  logic good_beat, bad_beat, last_in_pkt, finish, zero_start, take_req;

  assign bb          = burst_beats(ctl_q.burst);
  assign good_beat   = beat_i & ~err_i & ~ctl_we_i;
  assign bad_beat    = beat_i & err_i & ~ctl_we_i;
  assign last_in_pkt = (pkt_q == CNT_W'(1));
  assign finish      = good_beat & last_in_pkt & (~ctl_q.mode | (cnt_q == CNT_W'(1)));
  assign zero_start  = ctl_q.en & ~act_q & (cnt_q == '0) & ~ctl_we_i;
  assign take_req    = ctl_q.en & ~act_q & ep_req_i & (cnt_q != '0) & ~ctl_we_i;
  assign done_o      = finish | zero_start | bad_beat;

  assign need_o = ctl_q.en & act_q;
  assign blen_o = (pkt_q < CNT_W'(bb)) ? pkt_q[LEN_W-1:0] : bb;
  assign ctl_o  = ctl_q;
  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      pkt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        ctl_q <= ctl_t'(wdata_i[CTL_W-1:0]);
        act_q <= 1'b0;
      end else begin
        if (zero_start) ctl_q.en <= 1'b0;
        if (take_req) begin
          act_q <= 1'b1;
          pkt_q <= (cnt_q > CNT_W'(PKT_BYTES)) ? CNT_W'(PKT_BYTES) : cnt_q;
        end
        if (bad_beat) begin
          ctl_q.berr <= 1'b1;
          ctl_q.en   <= 1'b0;
          act_q      <= 1'b0;
        end else if (good_beat) begin
          pkt_q <= pkt_q - CNT_W'(1);
          if (last_in_pkt) act_q <= 1'b0;
          if (finish) ctl_q.en <= 1'b0;
        end
      end
      if (addr_we_i)      addr_q <= wdata_i[AW-1:0];
      else if (good_beat) addr_q <= addr_q + AW'(1);
      if (cnt_we_i)       cnt_q <= wdata_i[CNT_W-1:0];
      else if (good_beat) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R5: a beat only lands inside an open packet with bytes left
  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i |-> (act_q && cnt_q != '0 && pkt_q != '0));

  // R10: an error beat leaves the channel stopped with its flag set
  p_err_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_beat |=> (!ctl_q.en && ctl_q.berr));
endmodule

// File: rtl/ep_dma_rr_arb.sv
module ep_dma_rr_arb #(
  parameter int NCH = 8,
  parameter int IDW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic           en_i,
  output logic           gnt_any_o,
  output logic [IDW-1:0] gnt_id_o
);
  logic [IDW-1:0] ptr_q;
  logic           hit;

  always_comb begin
    hit      = 1'b0;
    gnt_id_o = ptr_q;
    for (int k = 1; k <= NCH; k++) begin
      if (!hit && req_i[(int'(ptr_q) + k) % NCH]) begin
        hit      = 1'b1;
        gnt_id_o = IDW'((int'(ptr_q) + k) % NCH);
      end
    end
  end

  assign gnt_any_o = en_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (gnt_any_o) ptr_q <= gnt_id_o;
  end

  p_gnt_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_any_o |-> req_i[gnt_id_o]);

  // R9: the last winner yields while anyone else waits
  p_rr_yield_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_any_o && $countones(req_i) > 1) |-> (gnt_id_o != ptr_q));
endmodule

// File: rtl/ep_dma_port.sv
module ep_dma_port
  import ep_dma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int IDW = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCH-1:0]            need_i,
  input  logic [NCH-1:0][AW-1:0]    addr_i,
  input  logic [NCH-1:0][LEN_W-1:0] blen_i,
  input  logic [NCH-1:0]            dir_i,
  input  logic                      gnt_any_i,
  input  logic [IDW-1:0]            gnt_id_i,
  input  logic                      mem_ready_i,
  input  logic                      mem_err_i,
  output logic                      idle_o,
  output logic [NCH-1:0]            beat_o,
  output logic                      mem_valid_o,
  output logic                      mem_write_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [LEN_W-1:0]          mem_len_o,
  output logic                      mem_last_o,
  output logic [IDW-1:0]            mem_chan_o
);
  logic             busy_q;
  logic [IDW-1:0]   cur_q;
  logic [LEN_W-1:0] len_q, idx_q;

  assign idle_o      = ~busy_q;
  assign mem_valid_o = busy_q & need_i[cur_q];
  assign mem_write_o = ~dir_i[cur_q];
  assign mem_addr_o  = addr_i[cur_q];
  assign mem_len_o   = len_q;
  assign mem_last_o  = (idx_q == len_q - LEN_W'(1));
  assign mem_chan_o  = cur_q;

  for (genvar i = 0; i < NCH; i++) begin : g_beat
    assign beat_o[i] = mem_valid_o & mem_ready_i & (cur_q == IDW'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (gnt_any_i) begin
        busy_q <= 1'b1;
        cur_q  <= gnt_id_i;
        len_q  <= blen_i[gnt_id_i];
        idx_q  <= '0;
      end
    end else if (!need_i[cur_q]) begin
      busy_q <= 1'b0;
    end else if (mem_ready_i) begin
      if (mem_err_i || mem_last_o) busy_q <= 1'b0;
      else                         idx_q  <= idx_q + LEN_W'(1);
    end
  end

  p_len_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (len_q != '0 && idx_q < len_q && len_q <= LEN_W'(16)));

  p_one_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(beat_o));
endmodule

// File: rtl/ep_dma_engine.sv
module ep_dma_engine
  import ep_dma_pkg::*;
#(
  parameter int NCH       = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int RA_W      = 12,
  parameter int CNT_W     = 17,
  parameter int PKT_BYTES = 64,
  parameter int BASE      = 'h200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [NCH-1:0]   ep_req_i,
  output logic             irq_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  input  logic             mem_err_i,
  output logic             mem_write_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [LEN_W-1:0] mem_len_o,
  output logic             mem_last_o,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] mem_chan_o
);
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [RA_W-1:0] BASE_A = RA_W'(BASE);
  localparam logic [RA_W-1:0] SPAN   = RA_W'(NCH * 16);

  logic [RA_W-1:0] off;
  logic [IDW-1:0]  ch_sel;
  logic [3:0]      sub;
  logic            in_rng, rd_stat;

  assign off     = reg_addr_i - BASE_A;
  assign in_rng  = (reg_addr_i >= BASE_A) && (off < SPAN);
  assign ch_sel  = off[IDW+3:4];
  assign sub     = off[3:0];
  assign rd_stat = reg_re_i & in_rng & (ch_sel == '0) & (sub == 4'h0);

  ctl_t [NCH-1:0]            ctl;
  logic [NCH-1:0][AW-1:0]    addr;
  logic [NCH-1:0][CNT_W-1:0] cnt;
  logic [NCH-1:0][LEN_W-1:0] blen;
  logic [NCH-1:0]            need, dir, beat, done, set;
  logic [NCH-1:0]            stat_q;
  logic                      gnt_any, port_idle;
  logic [IDW-1:0]            gnt_id;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit    = reg_we_i & in_rng & (ch_sel == IDW'(i));
    assign dir[i] = ctl[i].dir;
    assign set[i] = done[i] & ctl[i].ie;

    ep_dma_chan #(
      .DW(DW), .AW(AW), .CNT_W(CNT_W), .PKT_BYTES(PKT_BYTES)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_we_i (hit & (sub == 4'h4)),
      .addr_we_i(hit & (sub == 4'h8)),
      .cnt_we_i (hit & (sub == 4'hC)),
      .wdata_i  (reg_wdata_i),
      .ep_req_i (ep_req_i[i]),
      .beat_i   (beat[i]),
      .err_i    (mem_err_i),
      .ctl_o    (ctl[i]),
      .addr_o   (addr[i]),
      .cnt_o    (cnt[i]),
      .need_o   (need[i]),
      .blen_o   (blen[i]),
      .done_o   (done[i])
    );

    // R11: a status bit only rises for a channel with interrupts enabled
    p_stat_needs_ie_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[i]) |-> $past(ctl[i].ie));
  end

  ep_dma_rr_arb #(.NCH(NCH), .IDW(IDW)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (need),
    .en_i     (port_idle),
    .gnt_any_o(gnt_any),
    .gnt_id_o (gnt_id)
  );

  ep_dma_port #(.NCH(NCH), .AW(AW), .IDW(IDW)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .need_i     (need),
    .addr_i     (addr),
    .blen_i     (blen),
    .dir_i      (dir),
    .gnt_any_i  (gnt_any),
    .gnt_id_i   (gnt_id),
    .mem_ready_i(mem_ready_i),
    .mem_err_i  (mem_err_i),
    .idle_o     (port_idle),
    .beat_o     (beat),
    .mem_valid_o(mem_valid_o),
    .mem_write_o(mem_write_o),
    .mem_addr_o (mem_addr_o),
    .mem_len_o  (mem_len_o),
    .mem_last_o (mem_last_o),
    .mem_chan_o (mem_chan_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (rd_stat ? '0 : stat_q) | set;
  end

  assign irq_o = |stat_q;

  always_comb begin
    reg_rdata_o = '0;
    if (in_rng) begin
      case (sub)
        4'h0: if (ch_sel == '0) reg_rdata_o = DW'(stat_q);
        4'h4: reg_rdata_o = DW'(ctl[ch_sel]);
        4'h8: reg_rdata_o = DW'(addr[ch_sel]);
        4'hC: reg_rdata_o = DW'(cnt[ch_sel]);
        default: ;
      endcase
    end
  end

  p_read_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && set == '0) |=> (stat_q == '0));
endmodule

// File: tb/sim_ep_dma_engine.sv
module sim_ep_dma_engine;
  localparam int NCH = 8;
  localparam int PKT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 0, reg_re = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  ep_req = '0;
  logic        irq_o, mem_valid_o, mem_write_o, mem_last_o;
  logic        mem_ready = 1'b1, mem_err = 1'b0;
  logic [31:0] mem_addr_o;
  logic [4:0]  mem_len_o;
  logic [2:0]  mem_chan_o;

  always #10 clk = ~clk;

  ep_dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ep_req_i(ep_req), .irq_o(irq_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready), .mem_err_i(mem_err),
    .mem_write_o(mem_write_o), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
    .mem_last_o(mem_last_o), .mem_chan_o(mem_chan_o)
  );

  int n_chk = 0, n_bad = 0;
  longint m_addr[NCH], m_cnt[NCH], m_pkt[NCH];
  int     m_bb[NCH];
  bit     m_en[NCH], m_act[NCH], m_mode[NCH], m_dir[NCH], m_ie[NCH];
  bit [7:0] m_stat = '0;
  bit     m_inb = 0;
  int     m_cur = 0, m_rem = 0;
  int     starts[$];
  bit     inj = 0;
  bit     done_flag = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bbeats(int code);
    case (code) 1: return 4; 2: return 8; 3: return 16; default: return 1; endcase
  endfunction

  // reference model, stepped a quarter period before each rising edge
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      chk("R11 irq level", irq_o, m_stat != 0);
      if (reg_re && reg_addr == 12'h200) m_stat = '0;
      if (mem_valid_o) begin
        int c;
        c = mem_chan_o;
        if (!m_inb) begin
          longint e;
          e = (m_pkt[c] < m_bb[c]) ? m_pkt[c] : m_bb[c];
          chk("R6 burst length", mem_len_o, e);
          m_inb = 1; m_cur = c; m_rem = int'(e);
          starts.push_back(c);
        end else chk("R9 burst holds channel", c, m_cur);
        chk("R4 beat address", mem_addr_o, m_addr[c]);
        chk("R4 direction", mem_write_o, !m_dir[c]);
        chk("R3 beat only for open packet", m_act[c], 1);
        if (mem_ready) begin
          if (mem_err) begin
            m_inb = 0; m_en[c] = 0; m_act[c] = 0;
            if (m_ie[c]) m_stat[c] = 1;
          end else begin
            m_addr[c]++; m_cnt[c]--; m_pkt[c]--; m_rem--;
            if (m_rem == 0) m_inb = 0;
            if (m_pkt[c] == 0) begin
              m_act[c] = 0;
              if (!m_mode[c] || m_cnt[c] == 0) begin
                m_en[c] = 0;
                if (m_ie[c]) m_stat[c] = 1;
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk)
    mem_err = inj && mem_valid_o && mem_chan_o == 3'd4 && m_addr[4] == 64'h2000_0002;

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    #5 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic prog(input int ch, input logic [31:0] a, input logic [31:0] n,
                      input logic [15:0] ctl);
    logic [11:0] b;
    b = 12'h200 + 12'(ch * 16);
    wr(b + 12'h8, a); m_addr[ch] = a;
    wr(b + 12'hC, n); m_cnt[ch] = n;
    wr(b + 12'h4, {16'h0, ctl});
    m_en[ch] = ctl[0]; m_dir[ch] = ctl[1]; m_mode[ch] = ctl[2];
    m_ie[ch] = ctl[3]; m_bb[ch] = bbeats(int'(ctl[10:9])); m_act[ch] = 0;
  endtask

  task automatic pulse(input logic [7:0] mask);
    @(negedge clk); ep_req = mask;
    for (int c = 0; c < NCH; c++)
      if (mask[c] && m_en[c] && !m_act[c] && m_cnt[c] != 0) begin
        m_act[c] = 1; m_pkt[c] = (m_cnt[c] > PKT) ? PKT : m_cnt[c];
      end
    @(negedge clk); ep_req = '0;
  endtask

  task automatic wait_idle(input int ch);
    while (m_act[ch]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", irq_o, 0);
    chk("R1 no beat after reset", mem_valid_o, 0);
    rd(12'h200, d); chk("R1 status reset", d, 0);
    rd(12'h204, d); chk("R1 control reset", d, 0);
    rd(12'h278, d); chk("R1 address reset", d, 0);

    // R2 control readback with enable clear; R5 count capacity
    wr(12'h204, 32'h6F6);
    rd(12'h204, d); chk("R2 control readback", d, 32'h6F6);
    wr(12'h27C, 32'h10000);
    rd(12'h27C, d); chk("R5 count holds 0x10000", d, 32'h10000);

    // R8 mode 1, transmit, 16-beat bursts, 100 bytes
    prog(0, 32'h1000_0000, 100, 16'h63F);
    repeat (5) @(negedge clk);
    chk("R3 no beat before request", mem_valid_o, 0);
    pulse(8'h01); wait_idle(0);
    rd(12'h208, d); chk("R8 address after first packet", d, 32'h1000_0040);
    rd(12'h20C, d); chk("R8 count after first packet", d, 36);
    rd(12'h204, d); chk("R8 enable held between packets", d, 32'h63F);
    pulse(8'h01); wait_idle(0);
    rd(12'h208, d); chk("R4 bytes moved = address - start", d - 32'h1000_0000, 100);
    rd(12'h20C, d); chk("R8 count drained", d, 0);
    rd(12'h204, d); chk("R8 enable cleared at end", d, 32'h63E);
    chk("R11 irq after completion", irq_o, 1);
    rd(12'h200, d); chk("R11 status bit 0", d, 32'h01);
    rd(12'h200, d); chk("R11 status cleared by read", d, 0);

    // R7 mode 0, receive, 8-beat bursts: one packet only
    prog(1, 32'h0000_3000, 200, 16'h419);
    pulse(8'h02); wait_idle(1);
    rd(12'h218, d); chk("R7 one packet moved", d, 32'h0000_3040);
    rd(12'h21C, d); chk("R7 count left", d, 136);
    rd(12'h214, d); chk("R7 enable cleared after packet", d, 32'h418);
    rd(12'h200, d); chk("R11 status bit 1", d, 32'h02);

    // R9 two channels competing, interrupts off
    prog(2, 32'h0000_4000, 32, 16'h401);
    prog(3, 32'h0000_5000, 32, 16'h401);
    starts.delete();
    pulse(8'h0C); wait_idle(2); wait_idle(3);
    chk("R9 burst count", starts.size(), 8);
    for (int k = 1; k < starts.size(); k++)
      chk("R9 grants alternate", starts[k] != starts[k-1], 1);
    rd(12'h200, d); chk("R11 no status without enable", d, 0);

    // R10 bus error on third beat
    prog(4, 32'h2000_0000, 40, 16'h20D);
    inj = 1;
    pulse(8'h10); wait_idle(4);
    inj = 0;
    rd(12'h244, d); chk("R10 error flag set, enable clear", d, 32'h30C);
    rd(12'h248, d); chk("R10 address stops at faulting beat", d, 32'h2000_0002);
    rd(12'h24C, d); chk("R10 count after error", d, 38);
    rd(12'h200, d); chk("R10 status on error", d, 32'h10);

    // R12 abort while stalled
    mem_ready = 0;
    prog(6, 32'h0000_6000, 50, 16'h60D);
    pulse(8'h40);
    repeat (5) @(negedge clk);
    chk("R12 channel stalled before abort", mem_valid_o, 1);
    wr(12'h264, 0);
    m_en[6] = 0; m_act[6] = 0; m_inb = 0;
    wr(12'h268, 0); m_addr[6] = 0;
    wr(12'h26C, 0); m_cnt[6] = 0;
    mem_ready = 1;
    repeat (5) @(negedge clk);
    chk("R12 no beats after abort", mem_valid_o, 0);
    rd(12'h264, d); chk("R12 control zero", d, 0);
    rd(12'h268, d); chk("R12 address zero", d, 0);
    rd(12'h26C, d); chk("R12 count zero", d, 0);
    rd(12'h200, d); chk("R12 abort posts no status", d, 0);

    // R5/R6 large count, single-beat bursts, mode 0
    prog(7, 32'h0000_8000, 32'h10000, 16'h001);
    pulse(8'h80); wait_idle(7);
    rd(12'h27C, d); chk("R5 count after one packet", d, 32'hFFC0);
    rd(12'h278, d); chk("R6 address after single beats", d, 32'h0000_8040);
    chk("R11 irq stays low", irq_o, 0);

    finish_up();
  end
endmodule